// File: doc/BRIEF.md
# Audio FIFO Error and Interrupt Status

This block watches the edges of an audio playback FIFO and an audio capture FIFO and records the four ways they can be misused. It also records pending interrupts from three counter sources: playback transfer, capture transfer and a timer. A converter that asks for a sample from an empty playback FIFO misses that sample. A host write into a full playback FIFO is thrown away. A converter sample offered to a full capture FIFO is thrown away. A host read from an empty capture FIFO returns the last valid byte again. For each case the block drives a control that same cycle, so the FIFO logic applies the right data consequence, and it also sets a sticky flag.

The flags form one 8-bit status byte that is updated on the clock edge after the event. Each flag stays set until its own clear strobe is applied. A single interrupt line is high while any of the three interrupt-pending flags is set. The FIFO storage, the transfer counters and the timer sit outside this block. It only sees their flags and strobes.

Top module: `aud_fifo_status`

## Requirements
- R1: After reset the status byte is 0x00 and `irq` is low.
- R2: When `dac_req` and `pb_empty` are both high in a cycle, `dac_miss` is high in that cycle and status bit 0 is set after the next clock edge.
- R3: When `host_wr` and `pb_full` are both high in a cycle, `host_wr_drop` is high in that cycle and status bit 1 is set after the next clock edge.
- R4: When `adc_load` and `cap_full` are both high in a cycle, `adc_drop` is high in that cycle and status bit 2 is set after the next clock edge.
- R5: When `host_rd` and `cap_empty` are both high in a cycle, `rd_replay` is high in that cycle and status bit 3 is set after the next clock edge.
- R6: A strobe whose FIFO flag is not in the error state leaves all four controls low and sets no status bit.
- R7: Pulses on `pb_irq_ev`, `cap_irq_ev` and `tmr_irq_ev` set status bits 4, 5 and 6 respectively after the next clock edge.
- R8: Every status bit stays set until bit i of `clr` is pulsed for that bit. Bit i is then low after the next edge, and the other bits keep their value.
- R9: If a bit's set event and its clear strobe come in the same cycle, the bit is set after the edge.
- R10: `irq` is high exactly when at least one of status bits 4, 5 or 6 is set.
- R11: Status bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_full | input | 1 | Playback FIFO is full |
| pb_empty | input | 1 | Playback FIFO is empty |
| cap_full | input | 1 | Capture FIFO is full |
| cap_empty | input | 1 | Capture FIFO is empty |
| host_wr | input | 1 | Host write strobe into playback FIFO |
| host_rd | input | 1 | Host read strobe from capture FIFO |
| dac_req | input | 1 | Output converter requests a playback sample |
| adc_load | input | 1 | Input converter loads a capture sample |
| pb_irq_ev | input | 1 | Playback counter interrupt event |
| cap_irq_ev | input | 1 | Capture counter interrupt event |
| tmr_irq_ev | input | 1 | Timer interrupt event |
| clr | input | 7 | Per-bit clear strobes, bit i clears status bit i |
| status | output | 8 | Sticky status byte |
| dac_miss | output | 1 | Requested playback sample is missed |
| host_wr_drop | output | 1 | Host write data is to be discarded |
| adc_drop | output | 1 | Converter capture sample is to be discarded |
| rd_replay | output | 1 | Host read returns the last valid byte again |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input has a known value at each rising edge after reset. They also assume that the FIFO flags that go with a strobe are valid in the same cycle as that strobe, since both the controls and the flag updates come from that one sample. The stimulus drives every input on the falling clock edge and holds it for a full cycle, so no value is unknown or changing at a rising edge. Every scenario, including events colliding with clears and strobes arriving against healthy FIFOs, is built from such single-cycle vectors.

// File: rtl/afs_pkg.sv
package afs_pkg;
    localparam int ERR_W  = 4;
    localparam int IRQ_W  = 3;
    localparam int FLAG_W = ERR_W + IRQ_W;
    localparam int STAT_W = FLAG_W + 1;

    // status bit positions
    localparam int B_PB_UNDER  = 0;
    localparam int B_PB_OVER   = 1;
    localparam int B_CAP_OVER  = 2;
    localparam int B_CAP_UNDER = 3;
    localparam int B_PB_IRQ    = 4;
    localparam int B_CAP_IRQ   = 5;
    localparam int B_TMR_IRQ   = 6;

    typedef struct packed {
        logic cap_under;
        logic cap_over;
        logic pb_over;
        logic pb_under;
    } err_ev_t;

    typedef struct packed {
        logic replay_rd;
        logic drop_adc;
        logic drop_host_wr;
        logic miss_dac;
    } fifo_ctl_t;
endpackage

// File: rtl/afs_err_detect.sv
module afs_err_detect
    import afs_pkg::*;
(
    input  logic      pb_full,
    input  logic      pb_empty,
    input  logic      cap_full,
    input  logic      cap_empty,
    input  logic      host_wr,
    input  logic      host_rd,
    input  logic      dac_req,
    input  logic      adc_load,
    output err_ev_t   err_o,
    output fifo_ctl_t ctl_o
);
    // Each error is the coincidence of a strobe with the wrong FIFO state.
    always_comb begin
        err_o          = '0;
        err_o.pb_under  = dac_req  & pb_empty;
        err_o.pb_over   = host_wr  & pb_full;
        err_o.cap_over  = adc_load & cap_full;
        err_o.cap_under = host_rd  & cap_empty;

        ctl_o              = '0;
        ctl_o.miss_dac     = err_o.pb_under;
        ctl_o.drop_host_wr = err_o.pb_over;
        ctl_o.drop_adc     = err_o.cap_over;
        ctl_o.replay_rd    = err_o.cap_under;
    end
endmodule

// File: rtl/afs_sticky_bank.sv
module afs_sticky_bank #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t bank_d, bank_q;

    // set has priority over clear
    always_comb begin
        bank_d       = bank_q;
        bank_d.flags = (bank_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign flag_o = bank_q.flags;

    for (genvar g = 0; g < W; g++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_o[g]); // R9
        AST_HOLD_UNTIL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[g] && !clr_i[g]) |=> flag_o[g]); // R8
        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_o[g]); // R8
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_o[g] && !set_i[g]) |=> !flag_o[g]); // R6
    end
endmodule

// File: rtl/aud_fifo_status.sv
module aud_fifo_status
    import afs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pb_full,
    input  logic       pb_empty,
    input  logic       cap_full,
    input  logic       cap_empty,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       dac_req,
    input  logic       adc_load,
    input  logic       pb_irq_ev,
    input  logic       cap_irq_ev,
    input  logic       tmr_irq_ev,
    input  logic [6:0] clr,
    output logic [7:0] status,
    output logic       dac_miss,
    output logic       host_wr_drop,
    output logic       adc_drop,
    output logic       rd_replay,
    output logic       irq
);
    err_ev_t           err;
    fifo_ctl_t         ctl;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flags;

    afs_err_detect u_detect (
        .pb_full  (pb_full),
        .pb_empty (pb_empty),
        .cap_full (cap_full),
        .cap_empty(cap_empty),
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .dac_req  (dac_req),
        .adc_load (adc_load),
        .err_o    (err),
        .ctl_o    (ctl)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[ERR_W-1:0]   = err;
        set_vec[B_PB_IRQ]    = pb_irq_ev;
        set_vec[B_CAP_IRQ]   = cap_irq_ev;
        set_vec[B_TMR_IRQ]   = tmr_irq_ev;
    end

    afs_sticky_bank #(.W(FLAG_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr),
        .flag_o(flags)
    );

    assign status       = {1'b0, flags};
    assign dac_miss     = ctl.miss_dac;
    assign host_wr_drop = ctl.drop_host_wr;
    assign adc_drop     = ctl.drop_adc;
    assign rd_replay    = ctl.replay_rd;
    assign irq          = |flags[B_TMR_IRQ:B_PB_IRQ];

    AST_MISS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        dac_miss |=> status[B_PB_UNDER]); // R2
    AST_WR_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_drop |=> status[B_PB_OVER]); // R3
    AST_ADC_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        adc_drop |=> status[B_CAP_OVER]); // R4
    AST_REPLAY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_replay |=> status[B_CAP_UNDER]); // R5
    AST_TMR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq_ev |=> irq); // R10
    AST_IRQ_FALLS_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (&clr[B_TMR_IRQ:B_PB_IRQ] && !pb_irq_ev && !cap_irq_ev && !tmr_irq_ev) |=> !irq); // R10
endmodule

// File: tb/aud_fifo_status_bench.sv
`timescale 1ns/1ps
module aud_fifo_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pb_full = 0, pb_empty = 0, cap_full = 0, cap_empty = 0;
    logic host_wr = 0, host_rd = 0, dac_req = 0, adc_load = 0;
    logic pb_irq_ev = 0, cap_irq_ev = 0, tmr_irq_ev = 0;
    logic [6:0] clr = '0;
    logic [7:0] status;
    logic dac_miss, host_wr_drop, adc_drop, rd_replay, irq;

    always #2.5 clk = ~clk;

    aud_fifo_status u_aud_fifo_status (
        .clk(clk), .rst_n(rst_n),
        .pb_full(pb_full), .pb_empty(pb_empty), .cap_full(cap_full), .cap_empty(cap_empty),
        .host_wr(host_wr), .host_rd(host_rd), .dac_req(dac_req), .adc_load(adc_load),
        .pb_irq_ev(pb_irq_ev), .cap_irq_ev(cap_irq_ev), .tmr_irq_ev(tmr_irq_ev),
        .clr(clr), .status(status), .dac_miss(dac_miss), .host_wr_drop(host_wr_drop),
        .adc_drop(adc_drop), .rd_replay(rd_replay), .irq(irq)
    );

    typedef struct {
        string      tag;
        logic [3:0] ctl;   // {replay, adc_drop, wr_drop, miss}
        logic [7:0] stat;
        logic       irq;
    } item_t;

    item_t      sb[$];
    logic [7:0] model = '0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: one stimulus cycle, expected result pushed to the scoreboard
    task automatic step(input string tag,
                        input logic dq, input logic pe, input logic hw, input logic pf,
                        input logic al, input logic cf, input logic hr, input logic ce,
                        input logic [2:0] iev, input logic [6:0] cl);
        item_t it;
        logic [3:0] ev;
        @(negedge clk);
        dac_req = dq; pb_empty = pe; host_wr = hw; pb_full = pf;
        adc_load = al; cap_full = cf; host_rd = hr; cap_empty = ce;
        {tmr_irq_ev, cap_irq_ev, pb_irq_ev} = iev;
        clr = cl;
        ev = {hr & ce, al & cf, hw & pf, dq & pe};
        model = {1'b0, (model[6:0] & ~cl) | {iev, ev}};
        it.tag = tag;
        it.ctl = ev;
        it.stat = model;
        it.irq = |model[6:4];
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        {dac_req, pb_empty, host_wr, pb_full, adc_load, cap_full, host_rd, cap_empty} = '0;
        {tmr_irq_ev, cap_irq_ev, pb_irq_ev} = '0;
        clr = '0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk(it.tag, "ctl", {4'h0, rd_replay, adc_drop, host_wr_drop, dac_miss}, {4'h0, it.ctl});
                #1;
                chk(it.tag, "status", status, it.stat);
                chk(it.tag, "irq", {7'h0, irq}, {7'h0, it.irq});
                chk("R11", "bit7", {7'h0, status[7]}, 8'h0);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1", "reset status", status, 8'h00);
        chk("R1", "reset irq", {7'h0, irq}, 8'h0);
        // R6: strobes against healthy FIFOs
        step("R6", 1,0, 1,0, 1,0, 1,0, 3'b000, 7'h00);
        step("R6", 0,1, 0,1, 0,1, 0,1, 3'b000, 7'h00);
        // R2..R5 individually
        step("R2", 1,1, 0,0, 0,0, 0,0, 3'b000, 7'h00);
        idle();
        step("R3", 0,0, 1,1, 0,0, 0,0, 3'b000, 7'h00);
        step("R4", 0,0, 0,0, 1,1, 0,0, 3'b000, 7'h00);
        step("R5", 0,0, 0,0, 0,0, 1,1, 3'b000, 7'h00);
        // R8: clear one bit, others stay
        step("R8", 0,0, 0,0, 0,0, 0,0, 3'b000, 7'h02);
        step("R8", 0,0, 0,0, 0,0, 0,0, 3'b000, 7'h0D);
        // R7 / R10: interrupt sources
        step("R7", 0,0, 0,0, 0,0, 0,0, 3'b001, 7'h00);
        step("R10", 0,0, 0,0, 0,0, 0,0, 3'b000, 7'h10);
        step("R7", 0,0, 0,0, 0,0, 0,0, 3'b010, 7'h00);
        step("R7", 0,0, 0,0, 0,0, 0,0, 3'b100, 7'h00);
        step("R10", 0,0, 0,0, 0,0, 0,0, 3'b000, 7'h20);
        step("R10", 0,0, 0,0, 0,0, 0,0, 3'b000, 7'h40);
        // R9: event and clear together
        step("R9", 1,1, 1,1, 0,0, 0,0, 3'b100, 7'h43);
        step("R9", 0,0, 0,0, 1,1, 1,1, 3'b011, 7'h7F);
        step("R8", 0,0, 0,0, 0,0, 0,0, 3'b000, 7'h00);
        step("R8", 0,0, 0,0, 0,0, 0,0, 3'b000, 7'h7F);
        // mixed: all errors at once
        step("R2", 1,1, 1,1, 1,1, 1,1, 3'b000, 7'h00);
        step("R6", 1,0, 1,0, 1,0, 1,0, 3'b000, 7'h0F);
        idle();
        repeat (3) @(posedge clk);
        #1;
        finish_run();
    end
endmodule